// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the pin timing an 8-bit controller core needs to reach external code and data memory. It counts oscillator periods into a machine cycle of twelve slots and, from the request held for that cycle, drives one low port that carries first an address byte and then data. It also drives a high address port, an address latch pulse that tells an external latch to hold the low address byte, an active-low code read enable, and active-low data read and data write strobes.

The core presents a request kind, a 16-bit address, write data and the level of a code-source pin. These inputs are taken only on the clock edge that ends a machine cycle. A code fetch brings in two consecutive bytes in one machine cycle, one per half. A data read or data write uses the whole machine cycle for a single byte. When the code-source pin is high the code is internal, so a fetch causes no bus activity. A one-clock done pulse follows each non-idle machine cycle, and the captured bytes are valid while it is high.

Top module: `extbus_sequencer`

## Requirements
- R1: While rstN is low, and in the first clock after it rises, addrLatch is 0, codeRdN, dataRdN and dataWrN are 1, busLoOe is 0 and done is 0. Slot 0 of the first machine cycle is the second clock after reset rises.
- R2: A machine cycle is 12 clocks (slots 0 to 11). addrLatch is high in slots 0, 1, 6 and 7, except in slots 6 and 7 of a data read or data write cycle.
- R3: reqKind encodes 0 = idle, 1 = code fetch, 2 = data read, 3 = data write. reqKind, reqAddr, reqWdata and extCodeN are sampled only on the clock edge that ends slot 11, or on the first edge after reset. Their values at any other edge have no effect. For a non-idle cycle, done is high for exactly one clock, in slot 0 of the next machine cycle.
- R4: A code fetch with extCodeN = 0 (address A) works as follows. busLoOut drives the low byte of A in slots 0-2 and the low byte of A+1 in slots 6-8, with busLoOe = 1. codeRdN is low in slots 3-5 and 9-11, and the port is released there. busHi carries the high byte of A in slots 0-5 and the high byte of A+1 (carry included, wrapping at 16 bits) in slots 6-11.
- R5: An external code fetch samples busLoIn on the edges that end slots 5 and 11. When done is high, rdData = {byte at A+1, byte at A}.
- R6: A code fetch with extCodeN = 1 keeps codeRdN high, busLoOe at 0 and busHi at 0, and still pulses done. rdData keeps its previous value.
- R7: In a data read, busLoOut drives the low address byte in slots 0-2, and busHi drives the high byte in all 12 slots. dataRdN is low in slots 3-10 and busLoOe is 0 in slots 3-11. busLoIn is sampled on the edge that ends slot 10. When done is high, rdData = {8'h00, byte read}.
- R8: In a data write, busLoOut drives the low address byte in slots 0-2 and reqWdata in slots 3-11, with busLoOe = 1. dataWrN is low in slots 3-10, and busHi drives the high address byte in all 12 slots.
- R9: dataRdN and dataWrN are never low in a clock where codeRdN is low, and they are never low together.
- R10: In an idle cycle, codeRdN, dataRdN and dataWrN stay high, busLoOe is 0 and busHi is 0. No done pulse follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one slot per period |
| rstN | input | 1 | Asynchronous active-low reset |
| reqKind | input | 2 | Request kind: 0 idle, 1 fetch, 2 read, 3 write |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Byte to write for a data write |
| extCodeN | input | 1 | Code source pin: 0 external, 1 internal |
| busLoIn | input | 8 | Value seen on the low port pins |
| busLoOut | output | 8 | Value driven on the low port |
| busLoOe | output | 1 | Low port output enable |
| busHi | output | 8 | High address port |
| addrLatch | output | 1 | Address latch pulse, high active |
| codeRdN | output | 1 | External code read enable, active low |
| dataRdN | output | 1 | External data read strobe, active low |
| dataWrN | output | 1 | External data write strobe, active low |
| rdData | output | 16 | Captured bytes, valid with done |
| done | output | 1 | One-clock pulse after a non-idle cycle |

## Verification
Two things share the edge that ends slot 11. One is the final capture of the current operation: the second code byte of a fetch, plus the done it produces. The other is the latch of the next request. The bench provokes this by issuing requests back to back, with the kind, address and code-source pin changing every machine cycle. Between latch edges it puts random values on the request inputs. A reference model is compared on every clock. It judges that done and rdData belong to the finished operation and that the bus pattern of the new cycle belongs to the new request. The memory model gives valid data only in the last slot of each strobe window, so a capture taken on the wrong edge shows up as a wrong byte.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } busOpE;

  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveData;
    logic upperFetch;
    logic hiEn;
    logic capLo;
    logic capHi;
    logic capRead;
  } busStrobeS;

endpackage

// File: rtl/extbus_slot_timer.sv
module extbus_slot_timer #(
  parameter int SLOT_COUNT = 12,
  localparam int SLOT_W = $clog2(SLOT_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [SLOT_W-1:0] slot,
  output logic              running,
  output logic              lastSlot
);

  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(SLOT_COUNT - 1);

  assign lastSlot = (slot == LAST_S);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot    <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      if (running) begin
        slot <= lastSlot ? '0 : slot + 1'b1;
      end
    end
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (running && slot == LAST_S) |=> (slot == '0)); // R2

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int SLOT_COUNT = 12,
  parameter int ALE_SLOTS  = 2,
  parameter int ADDR_SLOTS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] reqKind,
  input  logic       extCodeN,
  output busStrobeS  strb,
  output logic       addrLatch,
  output logic       codeRdN,
  output logic       dataRdN,
  output logic       dataWrN,
  output logic       done
);

  localparam int SLOT_W = $clog2(SLOT_COUNT);
  localparam int HALF   = SLOT_COUNT / 2;
  localparam logic [SLOT_W-1:0] HALF_S   = SLOT_W'(HALF);
  localparam logic [SLOT_W-1:0] LOHALF_S = SLOT_W'(HALF - 1);
  localparam logic [SLOT_W-1:0] LAST_S   = SLOT_W'(SLOT_COUNT - 1);
  localparam logic [SLOT_W-1:0] DSTART_S = SLOT_W'(ADDR_SLOTS);
  localparam logic [SLOT_W-1:0] DEND_S   = SLOT_W'(SLOT_COUNT - 2);
  localparam logic [SLOT_W-1:0] ALE_S    = SLOT_W'(ALE_SLOTS);
  localparam logic [SLOT_W-1:0] ADDR_S   = SLOT_W'(ADDR_SLOTS);

  logic [SLOT_W-1:0] slot;
  logic              running;
  logic              lastSlot;

  extbus_slot_timer #(.SLOT_COUNT(SLOT_COUNT)) i_timer (
    .clk      (clk),
    .rstN     (rstN),
    .slot     (slot),
    .running  (running),
    .lastSlot (lastSlot)
  );

  busOpE opQ;
  logic  extQ;

  logic              secondHalf;
  logic [SLOT_W-1:0] halfSlot;
  logic              fetchExt;
  logic              dataOp;
  logic              inDataWin;

  always_comb begin
    secondHalf = (slot >= HALF_S);
    halfSlot   = secondHalf ? (slot - HALF_S) : slot;
    fetchExt   = (opQ == OP_FETCH) && extQ;
    dataOp     = (opQ == OP_READ) || (opQ == OP_WRITE);
    inDataWin  = (slot >= DSTART_S) && (slot <= DEND_S);
  end

  // Request register: taken at the end of a machine cycle or on the first edge out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ  <= OP_IDLE;
      extQ <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= running && lastSlot && (opQ != OP_IDLE);
      if (strb.loadReq) begin
        opQ  <= busOpE'(reqKind);
        extQ <= !extCodeN;
      end
    end
  end

  // Pin strobes
  always_comb begin
    addrLatch = running && (halfSlot < ALE_S) && !(dataOp && secondHalf);
    codeRdN   = !(running && fetchExt && (halfSlot >= ADDR_S));
    dataRdN   = !(running && (opQ == OP_READ) && inDataWin);
    dataWrN   = !(running && (opQ == OP_WRITE) && inDataWin);
  end

  // Strobes to the datapath
  always_comb begin
    strb.loadReq    = !running || lastSlot;
    strb.driveAddr  = running && ((fetchExt && (halfSlot < ADDR_S)) ||
                                  (dataOp && (slot < ADDR_S)));
    strb.driveData  = running && (opQ == OP_WRITE) && (slot >= DSTART_S);
    strb.upperFetch = fetchExt && secondHalf;
    strb.hiEn       = running && (fetchExt || dataOp);
    strb.capLo      = running && fetchExt && (slot == LOHALF_S);
    strb.capHi      = running && fetchExt && (slot == LAST_S);
    strb.capRead    = running && (opQ == OP_READ) && (slot == DEND_S);
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !codeRdN |-> (dataRdN && dataWrN)); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!dataRdN && !dataWrN)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_DONE_AT_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (slot == '0)); // R3
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrLatch) |=> addrLatch); // R2

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W,
  localparam int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobeS               strb,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W-1:0]       busLoIn,
  output logic [DATA_W-1:0]       busLoOut,
  output logic                    busLoOe,
  output logic [HI_W-1:0]         busHi,
  output logic [LANES*DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [ADDR_W-1:0] fetchAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
    end else if (strb.loadReq) begin
      addrQ <= reqAddr;
      wdQ   <= reqWdata;
    end
  end

  always_comb begin
    fetchAddr = strb.upperFetch ? (addrQ + 1'b1) : addrQ;
    busLoOe   = strb.driveAddr || strb.driveData;
    if (strb.driveData) begin
      busLoOut = wdQ;
    end else if (strb.driveAddr) begin
      busLoOut = fetchAddr[DATA_W-1:0];
    end else begin
      busLoOut = '0;
    end
    busHi = strb.hiEn ? fetchAddr[ADDR_W-1:DATA_W] : '0;
  end

  // Capture lanes: lane 0 takes the first code byte or the read byte,
  // lane 1 takes the second code byte and is cleared by a data read
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic              capThis;
    logic              clrThis;
    logic [DATA_W-1:0] laneQ;
    if (ln == 0) begin : g_first
      assign capThis = strb.capLo || strb.capRead;
      assign clrThis = 1'b0;
    end else begin : g_second
      assign capThis = strb.capHi;
      assign clrThis = strb.capRead;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (capThis) begin
        laneQ <= busLoIn;
      end else if (clrThis) begin
        laneQ <= '0;
      end
    end
    assign rdData[ln*DATA_W +: DATA_W] = laneQ;
  end

endmodule

// File: rtl/extbus_sequencer.sv
module extbus_sequencer
  import extbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SLOT_COUNT = 12,
  parameter int ALE_SLOTS  = 2,
  parameter int ADDR_SLOTS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 extCodeN,
  input  logic [DATA_W-1:0]    busLoIn,
  output logic [DATA_W-1:0]    busLoOut,
  output logic                 busLoOe,
  output logic [ADDR_W-DATA_W-1:0] busHi,
  output logic                 addrLatch,
  output logic                 codeRdN,
  output logic                 dataRdN,
  output logic                 dataWrN,
  output logic [2*DATA_W-1:0]  rdData,
  output logic                 done
);

  busStrobeS strb;

  extbus_ctrl #(
    .SLOT_COUNT (SLOT_COUNT),
    .ALE_SLOTS  (ALE_SLOTS),
    .ADDR_SLOTS (ADDR_SLOTS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqKind   (reqKind),
    .extCodeN  (extCodeN),
    .strb      (strb),
    .addrLatch (addrLatch),
    .codeRdN   (codeRdN),
    .dataRdN   (dataRdN),
    .dataWrN   (dataWrN),
    .done      (done)
  );

  extbus_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busLoIn  (busLoIn),
    .busLoOut (busLoOut),
    .busLoOe  (busLoOe),
    .busHi    (busHi),
    .rdData   (rdData)
  );

  AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!codeRdN || !dataRdN) |-> !busLoOe); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrN |-> busLoOe); // R8

endmodule

// File: tb/test_extbus_sequencer.sv
module test_extbus_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 420;
  localparam int SLOTS      = 12;
  localparam int HALFS      = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWdata = 8'h0;
  logic        extCodeN = 1'b0;
  logic [7:0]  busLoIn = 8'hEE;
  logic [7:0]  busLoOut;
  logic        busLoOe;
  logic [7:0]  busHi;
  logic        addrLatch, codeRdN, dataRdN, dataWrN, done;
  logic [15:0] rdData;

  extbus_sequencer i_extbus_sequencer (
    .clk(clk), .rstN(rstN), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .extCodeN(extCodeN), .busLoIn(busLoIn),
    .busLoOut(busLoOut), .busLoOe(busLoOe), .busHi(busHi),
    .addrLatch(addrLatch), .codeRdN(codeRdN), .dataRdN(dataRdN),
    .dataWrN(dataWrN), .rdData(rdData), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  // Request queues
  int qKind[$];
  int qAddr[$];
  int qWd[$];
  int qEa[$];

  task automatic push(input int k, input int a, input int w, input int ea);
    qKind.push_back(k); qAddr.push_back(a); qWd.push_back(w); qEa.push_back(ea);
  endtask

  // Reference model state
  bit          mRun = 0;
  int          mSlot = 0;
  int          mOp = 0;
  logic [15:0] mA = 0;
  logic [7:0]  mWd = 0;
  bit          mExt = 0;
  bit          mDone = 0;
  logic [15:0] mRd = 0;
  int          pOp = 0;
  logic [15:0] pA = 0;
  logic [7:0]  pWd = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mSlot = 0; mOp = 0; mDone = 0; mRd = 16'h0; mExt = 0;
    end else begin
      mDone = mRun && (mSlot == SLOTS-1) && (mOp != 0);
      if (mDone) begin
        pOp = mOp; pA = mA; pWd = mWd;
        if (mOp == 1 && mExt) mRd = {memByte(mA + 16'd1), memByte(mA)};
        else if (mOp == 2)    mRd = {8'h00, memByte(mA)};
      end
      if (!mRun || mSlot == SLOTS-1) begin
        mOp = int'(reqKind); mA = reqAddr; mWd = reqWdata; mExt = !extCodeN;
      end
      if (mRun) mSlot = (mSlot == SLOTS-1) ? 0 : mSlot + 1;
      mRun = 1;
    end
  end

  // Bench-side external parts
  logic [7:0]  latchLo = 8'h0;
  logic [7:0]  ramData = 8'h0;
  logic [15:0] ramAddr = 16'h0;
  int          cyc = 0;

  always @(negedge clk) begin
    int half, loc;
    bit ext, dat;
    bit eAle, ePsen, eRd, eWr, eOe;
    logic [15:0] fa;
    logic [7:0] eOut, eHi;
    string tag;

    half = mSlot / HALFS;
    loc  = mSlot % HALFS;
    ext  = (mOp == 1) && mExt;
    dat  = (mOp == 2) || (mOp == 3);
    eAle  = mRun && (loc < 2) && !(dat && half == 1);
    ePsen = !(mRun && ext && loc >= 3);
    eRd   = !(mRun && mOp == 2 && mSlot >= 3 && mSlot <= 10);
    eWr   = !(mRun && mOp == 3 && mSlot >= 3 && mSlot <= 10);
    eOe   = mRun && ((ext && loc < 3) || (dat && mSlot < 3) || (mOp == 3 && mSlot >= 3));
    fa    = (ext && half == 1) ? mA + 16'd1 : mA;
    eOut  = (mOp == 3 && mSlot >= 3) ? mWd : fa[7:0];
    eHi   = (mRun && (ext || dat)) ? fa[15:8] : 8'h00;

    if (!mRun)                     tag = "R1";
    else if (mOp == 1 && mExt)     tag = "R4";
    else if (mOp == 1)             tag = "R6";
    else if (mOp == 2)             tag = "R7";
    else if (mOp == 3)             tag = "R8";
    else                           tag = "R10";

    chk(addrLatch == eAle, mRun ? "R2" : "R1", "addrLatch", 16'(addrLatch), 16'(eAle));
    chk(codeRdN == ePsen, tag, "codeRdN", 16'(codeRdN), 16'(ePsen));
    chk(dataRdN == eRd, tag, "dataRdN", 16'(dataRdN), 16'(eRd));
    chk(dataWrN == eWr, tag, "dataWrN", 16'(dataWrN), 16'(eWr));
    chk(busLoOe == eOe, tag, "busLoOe", 16'(busLoOe), 16'(eOe));
    if (eOe) chk(busLoOut == eOut, tag, "busLoOut", 16'(busLoOut), 16'(eOut));
    chk(busHi == eHi, tag, "busHi", 16'(busHi), 16'(eHi));
    chk(done == mDone, mRun ? "R3" : "R1", "done", 16'(done), 16'(mDone));
    chk(!(!codeRdN && (!dataRdN || !dataWrN)) && !(!dataRdN && !dataWrN),
        "R9", "strobe overlap", {13'h0, codeRdN, dataRdN, dataWrN}, 16'h7);
    if (mDone) begin
      if (pOp == 1 && rdData != mRd)
        chk(0, mExt ? "R5" : "R6", "rdData", rdData, mRd);
      else if (pOp == 1)
        chk(1, "R5", "rdData", rdData, mRd);
      if (pOp == 2) chk(rdData == mRd, "R7", "rdData", rdData, mRd);
      if (pOp == 3) begin
        chk(ramData == pWd, "R8", "ram data", 16'(ramData), 16'(pWd));
        chk(ramAddr == pA, "R8", "ram addr", ramAddr, pA);
      end
    end

    // Address latch and memories
    if (addrLatch) latchLo = busLoOut;
    if (!dataWrN) begin
      ramData = busLoOut;
      ramAddr = {busHi, latchLo};
    end
    if (!codeRdN && loc == HALFS-1)    busLoIn = memByte({busHi, latchLo});
    else if (!dataRdN && mSlot == 10) busLoIn = memByte({busHi, latchLo});
    else                              busLoIn = 8'hEE;

    // Reset schedule
    cyc++;
    if (cyc < 4) rstN = 1'b0;
    else if (cyc == 110 || cyc == 111) rstN = 1'b0;
    else rstN = 1'b1;

    // Request driver: values only matter on a latch edge (R3)
    if (rstN && (!mRun || mSlot == SLOTS-1)) begin
      if (qKind.size() > 0) begin
        reqKind  = 2'(qKind.pop_front());
        reqAddr  = 16'(qAddr.pop_front());
        reqWdata = 8'(qWd.pop_front());
        extCodeN = 1'(qEa.pop_front());
      end else begin
        reqKind = 2'd0; reqAddr = 16'($urandom); reqWdata = 8'($urandom); extCodeN = 1'($urandom);
      end
    end else begin
      reqKind  = 2'($urandom);
      reqAddr  = 16'($urandom);
      reqWdata = 8'($urandom);
      extCodeN = 1'($urandom);
    end

    if (cyc >= NCYC) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    push(1, 16'h1234, 8'h00, 0);   // external fetch
    push(1, 16'h12FF, 8'h00, 0);   // fetch with carry into high byte
    push(1, 16'h4000, 8'h00, 1);   // internal fetch, rdData held
    push(2, 16'h8001, 8'h00, 0);   // data read
    push(3, 16'h00AA, 8'h3C, 0);   // data write
    push(0, 16'h5555, 8'hFF, 0);   // idle
    push(3, 16'hFFFE, 8'hC3, 1);   // write ignores code source pin
    push(2, 16'hFFFF, 8'h00, 1);   // read at top of space
    push(1, 16'hFFFF, 8'h00, 0);   // fetch wrap to 0000
    push(1, 16'h0080, 8'h00, 1);   // internal fetch
    push(2, 16'h2040, 8'h00, 0);
    push(1, 16'h7F10, 8'h00, 0);
    push(3, 16'h3301, 8'h5A, 0);
    push(0, 16'h0000, 8'h00, 0);
    push(2, 16'h0102, 8'h00, 0);
    push(1, 16'hA5A5, 8'h00, 0);
    push(3, 16'h0F0F, 8'hA5, 0);
    push(1, 16'h00FF, 8'h00, 0);
    push(2, 16'hC000, 8'h00, 0);
    push(1, 16'hBEEF, 8'h00, 1);
    push(1, 16'h1000, 8'h00, 0);
    push(3, 16'h1001, 8'h77, 0);
    push(2, 16'h1001, 8'h00, 0);
    push(0, 16'h0000, 8'h00, 0);
    push(1, 16'h2222, 8'h00, 0);
    push(2, 16'h3333, 8'h00, 0);
    push(3, 16'h4444, 8'h99, 0);
    push(1, 16'h5555, 8'h00, 0);
    push(2, 16'h6666, 8'h00, 0);
    push(3, 16'h7777, 8'h11, 0);
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule